// File: doc/BRIEF.md
# Three-Wire Tuner Control Receiver

This block takes serial control words from a three-wire bus made of a data line, a bus clock and an enable strobe, and keeps three latched control fields for a tuner: a 4-bit band selection, a 15-bit divider ratio and a 7-bit test field. A word starts when enable rises. Each bus clock pulse inside the enable window is counted, and its data bit is shifted in. A latch group is loaded only when the pulse count reaches that group's transfer point. One exception exists: the divider group can also be loaded by enable falling after exactly 18 pulses. In that case the word is read as a 14-bit ratio and the top ratio bit is forced to zero.

The bus lines are asynchronous to the system clock `clk`. Each line passes through a synchronizer chain, and the bus edges are detected in the system clock domain. The bus must therefore run much slower than `clk`: each bus level must be held for at least three system clock cycles. The outputs are plain levels. A consumer reads them at any time, there is no handshake and no back-pressure. A latch changes only at the transfer point of its own group.

Top module: `tw_tuner_rx`

## Requirements
- R1: While `rst_n` is low, `band_q` is 0, `div_q` is `DIV_POR` (default 256) and `test_q` is 0.
- R2: Bus pulses 1 to 4 carry the band bits, first bit into `band_q[3]`. `band_q` loads on the falling bus clock edge of pulse 4. A word with fewer than 4 pulses leaves `band_q` unchanged.
- R3: In a word of 19 or more pulses, pulses 5 to 19 carry the ratio, first bit into `div_q[14]`. `div_q` loads on the falling bus clock edge of pulse 19.
- R4: If enable falls after exactly 18 complete pulses, `div_q` loads with bit 14 cleared, and bits 13..0 take the bits of pulses 5 to 18, first bit into bit 13.
- R5: If enable falls with fewer than 18 pulses received, `div_q` is unchanged, including its bit 14.
- R6: In a word of 34 or more pulses, pulses 20 to 26 carry the test bits, first bit into `test_q[6]`. `test_q` loads on the falling edge of pulse 34. The bits of pulses 27 to 34 drive no output.
- R7: A word that ends with fewer than 34 pulses leaves `test_q` unchanged.
- R8: Pulses after the 34th in one enable window change no output.
- R9: Bus clock edges and data changes while enable is low change no output.
- R10: A rising edge of enable restarts the pulse count, so a word that follows a cut-off word is decoded from its own first pulse.
- R11: Between its transfer points each latch holds its value. Example: the ratio does not change while pulses 5 to 18 are arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_dat | input | 1 | Serial data, taken on the rising bus clock edge |
| bus_sck | input | 1 | Bus clock |
| bus_en | input | 1 | Word enable, high during a word |
| band_q | output | 4 | Band-select latch |
| div_q | output | 15 | Divider-ratio latch |
| test_q | output | 7 | Test-field latch |

## Verification
The bench drives words of 3, 7, 10, 18, 19, 27, 34 and 40 pulses, and also bus clock pulses while enable is low.

- The 18-pulse and 19-pulse words differ only by one pulse. Between them they separate the cleared-top-bit ratio load at enable fall from the full ratio load on pulse 19. The previous ratio has bit 14 set, so a missing clear shows up in the output.
- The 3, 7 and 10 pulse words cut a word before or after the band transfer point, and each time the bench checks that the other latches keep their old values.
- The 27, 34 and 40 pulse words tell the test transfer point apart from early loads and from loads caused by extra pulses.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // One-cycle load strobes raised by the word sequencer.
  typedef struct packed {
    logic band_ld;
    logic div_ld;
    logic div_short_ld;
    logic test_ld;
  } tw_load_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tw_frame_seq.sv
module tw_frame_seq
  import tw_pkg::*;
#(
  parameter int BAND_W    = 4,
  parameter int DIV_W     = 15,
  parameter int FRAME_MAX = 34,
  parameter int SR_W      = 15,
  parameter int CNT_W     = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_lvl,
  input  logic            sck_lvl,
  input  logic            sdi,
  output tw_load_t        ld,
  output logic [SR_W-1:0] sreg,
  output logic [CNT_W-1:0] cnt
);

  localparam int DIV_END = BAND_W + DIV_W;

  logic en_d, sck_d;
  logic en_rise, en_fall, sck_rise, sck_fall;
  logic in_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      en_d  <= en_lvl;
      sck_d <= sck_lvl;
    end
  end

  assign en_rise  =  en_lvl & ~en_d;
  assign en_fall  = ~en_lvl &  en_d;
  assign sck_rise =  sck_lvl & ~sck_d;
  assign sck_fall = ~sck_lvl &  sck_d;
  assign in_word  =  en_lvl & ~en_rise;

  // Pulse counter saturates one above FRAME_MAX so later pulses match no point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (en_rise) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (in_word && sck_rise) begin
      if (cnt < CNT_W'(FRAME_MAX)) begin
        cnt  <= cnt + 1'b1;
        sreg <= {sreg[SR_W-2:0], sdi};
      end else begin
        cnt  <= CNT_W'(FRAME_MAX + 1);
      end
    end
  end

  always_comb begin
    ld              = '0;
    ld.band_ld      = in_word && sck_fall && (cnt == CNT_W'(BAND_W));
    ld.div_ld       = in_word && sck_fall && (cnt == CNT_W'(DIV_END));
    ld.test_ld      = in_word && sck_fall && (cnt == CNT_W'(FRAME_MAX));
    ld.div_short_ld = en_fall && (cnt == CNT_W'(DIV_END - 1));
  end

endmodule

// File: rtl/tw_latch_bank.sv
module tw_latch_bank
  import tw_pkg::*;
#(
  parameter int BAND_W  = 4,
  parameter int DIV_W   = 15,
  parameter int TEST_W  = 7,
  parameter int SR_W    = 15,
  parameter int TEST_HI = 14,
  parameter int DIV_POR = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tw_load_t          ld,
  input  logic [SR_W-1:0]   sreg,
  output logic [BAND_W-1:0] band_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [TEST_W-1:0] test_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= '0;
      div_q  <= DIV_W'(DIV_POR);
      test_q <= '0;
    end else begin
      if (ld.band_ld)      band_q <= sreg[BAND_W-1:0];
      if (ld.div_ld)       div_q  <= sreg[DIV_W-1:0];
      else if (ld.div_short_ld)
                           div_q  <= {1'b0, sreg[DIV_W-2:0]};
      if (ld.test_ld)      test_q <= sreg[TEST_HI -: TEST_W];
    end
  end

endmodule

// File: rtl/tw_tuner_rx.sv
module tw_tuner_rx
  import tw_pkg::*;
#(
  parameter int BAND_W      = 4,
  parameter int DIV_W       = 15,
  parameter int TEST_W      = 7,
  parameter int FRAME_MAX   = 34,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_POR     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_dat,
  input  logic              bus_sck,
  input  logic              bus_en,
  output logic [BAND_W-1:0] band_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [TEST_W-1:0] test_q
);

  localparam int DIV_END = BAND_W + DIV_W;
  localparam int SR_W    = FRAME_MAX - DIV_END;
  localparam int TEST_HI = SR_W - 1;
  localparam int CNT_W   = $clog2(FRAME_MAX + 2);

  logic [2:0]       sync_q;
  logic             en_lvl, sck_lvl, dat_lvl;
  tw_load_t         ld;
  logic [SR_W-1:0]  sreg;
  logic [CNT_W-1:0] cnt;

  tw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bus_en, bus_sck, bus_dat}),
    .dout (sync_q)
  );

  assign {en_lvl, sck_lvl, dat_lvl} = sync_q;

  tw_frame_seq #(
    .BAND_W(BAND_W), .DIV_W(DIV_W), .FRAME_MAX(FRAME_MAX),
    .SR_W(SR_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_lvl (en_lvl),
    .sck_lvl(sck_lvl),
    .sdi    (dat_lvl),
    .ld     (ld),
    .sreg   (sreg),
    .cnt    (cnt)
  );

  tw_latch_bank #(
    .BAND_W(BAND_W), .DIV_W(DIV_W), .TEST_W(TEST_W),
    .SR_W(SR_W), .TEST_HI(TEST_HI), .DIV_POR(DIV_POR)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld),
    .sreg  (sreg),
    .band_q(band_q),
    .div_q (div_q),
    .test_q(test_q)
  );

endmodule

// File: rtl/tw_tuner_rx_chk.sv
module tw_tuner_rx_chk
  import tw_pkg::*;
#(
  parameter int BAND_W    = 4,
  parameter int DIV_W     = 15,
  parameter int TEST_W    = 7,
  parameter int FRAME_MAX = 34,
  parameter int DIV_POR   = 256,
  parameter int CNT_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BAND_W-1:0] band_q,
  input logic [DIV_W-1:0]  div_q,
  input logic [TEST_W-1:0] test_q,
  input tw_load_t          ld,
  input logic              en_lvl,
  input logic [CNT_W-1:0]  cnt
);

  a_r1_por_values: assert property (@(posedge clk)
    !rst_n |=> (band_q == '0 && div_q == DIV_W'(DIV_POR) && test_q == '0));

  a_r11_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld.band_ld |=> $stable(band_q));

  a_r11_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld.div_ld || ld.div_short_ld) |=> $stable(div_q));

  a_r7_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld.test_ld |=> $stable(test_q));

  a_r4_short_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ld.div_short_ld |=> (div_q[DIV_W-1] == 1'b0));

  a_r9_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_lvl && !$past(en_lvl)) |-> (ld == '0));

  a_r3_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld));

  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_MAX + 1));

endmodule

bind tw_tuner_rx tw_tuner_rx_chk #(
  .BAND_W(BAND_W), .DIV_W(DIV_W), .TEST_W(TEST_W),
  .FRAME_MAX(FRAME_MAX), .DIV_POR(DIV_POR), .CNT_W(CNT_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .band_q(band_q),
  .div_q (div_q),
  .test_q(test_q),
  .ld    (ld),
  .en_lvl(en_lvl),
  .cnt   (cnt)
);

// File: tb/sim_tw_tuner_rx.sv
module sim_tw_tuner_rx;

  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_dat = 1'b0, bus_sck = 1'b0, bus_en = 1'b0;
  logic [3:0]  band_q;
  logic [14:0] div_q;
  logic [6:0]  test_q;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  tw_tuner_rx u0 (
    .clk(clk), .rst_n(rst_n), .bus_dat(bus_dat), .bus_sck(bus_sck),
    .bus_en(bus_en), .band_q(band_q), .div_q(div_q), .test_q(test_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [39:0] mk34(input logic [3:0] b, input logic [14:0] d,
                                       input logic [6:0] t, input logic [7:0] f);
    return {b, d, t, f, 6'b0};
  endfunction

  function automatic logic [39:0] mk18(input logic [3:0] b, input logic [13:0] d);
    return {b, d, 22'b0};
  endfunction

  task automatic en_up();
    @(negedge clk); bus_en = 1'b1; idle(HALF);
  endtask

  task automatic en_down();
    idle(HALF); bus_en = 1'b0; idle(12);
  endtask

  // Sends pulses first..first+n-1 of vec (pulse k carries vec[40-k]).
  task automatic pulses(input logic [39:0] vec, input int first, input int n);
    for (int k = first; k < first + n; k++) begin
      bus_dat = vec[40-k];
      idle(HALF); bus_sck = 1'b1;
      idle(HALF); bus_sck = 1'b0;
    end
  endtask

  task automatic word(input logic [39:0] vec, input int n);
    en_up(); pulses(vec, 1, n); en_down();
  endtask

  task automatic t_reset();
    chk("R1", "band", band_q, 0);
    chk("R1", "div", div_q, 256);
    chk("R1", "test", test_q, 0);
  endtask

  task automatic t_idle_clock(input int b, input int d, input int t);
    bus_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      bus_dat = ~bus_dat;
      idle(HALF); bus_sck = 1'b1; idle(HALF); bus_sck = 1'b0;
    end
    idle(12);
    chk("R9", "band", band_q, b);
    chk("R9", "div", div_q, d);
    chk("R9", "test", test_q, t);
  endtask

  task automatic t_word19();
    word(mk34(4'hA, 15'h5A3C, 7'h7F, 8'hFF), 19);
    chk("R2", "band", band_q, 'hA);
    chk("R3", "div", div_q, 'h5A3C);
    chk("R7", "test", test_q, 0);
  endtask

  task automatic t_midword();
    logic [39:0] v = mk34(4'h3, 15'h1111, 7'h0, 8'h0);
    en_up(); pulses(v, 1, 10); idle(12);
    chk("R2", "band mid", band_q, 'h3);
    chk("R11", "div mid", div_q, 'h5A3C);
    en_down();
    chk("R5", "div cut at 10", div_q, 'h5A3C);
  endtask

  task automatic t_word18();
    word(mk18(4'h9, 14'h2BCD), 18);
    chk("R4", "div short", div_q, 'h2BCD);
    chk("R2", "band", band_q, 'h9);
  endtask

  task automatic t_cut3();
    word(mk34(4'hF, 15'h7FFF, 7'h7F, 8'hFF), 3);
    chk("R2", "band cut at 3", band_q, 'h9);
    chk("R5", "div cut at 3", div_q, 'h2BCD);
  endtask

  task automatic t_word34();
    word(mk34(4'h5, 15'h7ABC, 7'h55, 8'hC3), 34);
    chk("R6", "band", band_q, 'h5);
    chk("R6", "div", div_q, 'h7ABC);
    chk("R6", "test", test_q, 'h55);
  endtask

  task automatic t_cut27();
    word(mk34(4'h2, 15'h0123, 7'h0F, 8'h00), 27);
    chk("R7", "test cut at 27", test_q, 'h55);
    chk("R3", "div", div_q, 'h0123);
  endtask

  task automatic t_word40();
    logic [39:0] v = mk34(4'h6, 15'h0F0F, 7'h2A, 8'h81) | 40'h3F;
    word(v, 40);
    chk("R8", "band", band_q, 'h6);
    chk("R8", "div", div_q, 'h0F0F);
    chk("R8", "test", test_q, 'h2A);
  endtask

  task automatic t_rearm();
    word(mk34(4'hE, 15'h7FFF, 7'h7F, 8'hFF), 7);
    chk("R10", "band after cut", band_q, 'hE);
    word(mk34(4'h1, 15'h4321, 7'h11, 8'h00), 19);
    chk("R10", "band", band_q, 'h1);
    chk("R10", "div", div_q, 'h4321);
    chk("R7", "test", test_q, 'h2A);
  endtask

  initial begin
    idle(5);
    t_reset();
    rst_n = 1'b1;
    idle(5);
    t_idle_clock(0, 256, 0);
    t_word19();
    t_midword();
    t_word18();
    t_cut3();
    t_word34();
    t_cut27();
    t_word40();
    t_rearm();
    t_idle_clock(1, 'h4321, 'h2A);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule